// File: doc/BRIEF.md
# Joined Two-Operand Adder Stage

This block is one stage of a dataflow pipeline that adds two unsigned operands arriving on separate valid/ready streams and delivers their full-width sum on a third valid/ready stream. Each operand stream has its own handshake. Either stream can hand over its word first, and the block keeps that word in its own register while the other stream is still pending.

When both operand registers are occupied, the block offers the sum of the two stored words on the output stream. It holds that offer steady until the downstream reader takes it. When the output transfer completes, both registers become free again and the stage repeats the cycle: collect both operands, produce one sum, and continue.

The two inputs are never bundled into a single joint handshake. This means a producer that needs the result of one operand before it can supply the other cannot lock the stage up.

Top module: `join_adder`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `lhs_ready` and `rhs_ready` are 1, `sum_valid` is 0 and `sum_data` is 0, because both operand registers reset to zero.
- R2: Each output transfer carries the sum of the two operands captured since the previous output transfer, at `OPW+1` bits, so the carry out of the top operand bit is kept (for example, 0xFFFF + 0xFFFF gives 0x1FFFE).
- R3: `sum_valid` is 1 only when both operands are held. With only one operand captured, `sum_valid` stays 0.
- R4: The two operand handshakes complete independently. While its own register is empty, an input keeps `*_ready` high whether or not the other operand has arrived, and operands may arrive in either order.
- R5: After an input transfers, its `*_ready` is 0 until the output transfer completes. A `*_valid` presented in that window is ignored, and the stored operand is not changed.
- R6: While `sum_valid` is 1 and `sum_ready` is 0, in the next cycle `sum_valid` is still 1 and `sum_data` is unchanged.
- R7: In the cycle after an output transfer (`sum_valid` and `sum_ready` both 1 at a rising edge), `lhs_ready` and `rhs_ready` are 1 and `sum_valid` is 0.
- R8: If both operands transfer at the same rising edge, `sum_valid` is 1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| lhs_valid | input | 1 | Left operand offered |
| lhs_ready | output | 1 | Left operand register is empty |
| lhs_data | input | OPW | Left operand word |
| rhs_valid | input | 1 | Right operand offered |
| rhs_ready | output | 1 | Right operand register is empty |
| rhs_data | input | OPW | Right operand word |
| sum_valid | output | 1 | Sum offered to the reader |
| sum_ready | input | 1 | Reader takes the sum |
| sum_data | output | OPW+1 | Sum of the two held operands |

## Verification
Two events can land on the same clock edge: the capture of both operands, and, in a stream, the release of a finished sum followed by fresh operands already waiting on both inputs. The bench provokes the first event by raising both valids in the same cycle, and checks that `sum_valid` appears exactly one cycle later. It provokes the second by streaming operand pairs with zero gaps against a reader whose `sum_ready` toggles. Here the scoreboard confirms that each sum matches its own operand pair, with no word dropped or duplicated, while the monitor checks that the registers free up one cycle after each release.

// File: rtl/join_adder.sv
module join_adder #(
  parameter int OPW = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           lhs_valid,
  output logic           lhs_ready,
  input  logic [OPW-1:0] lhs_data,
  input  logic           rhs_valid,
  output logic           rhs_ready,
  input  logic [OPW-1:0] rhs_data,
  output logic           sum_valid,
  input  logic           sum_ready,
  output logic [OPW:0]   sum_data
);
  logic [OPW-1:0] lhs_q, rhs_q;
  logic           lhs_full, rhs_full;
  logic           lhs_take, rhs_take, sum_take;

  assign lhs_ready = !lhs_full;
  assign rhs_ready = !rhs_full;
  assign lhs_take  = lhs_valid && lhs_ready;
  assign rhs_take  = rhs_valid && rhs_ready;
  assign sum_valid = lhs_full && rhs_full;
  assign sum_take  = sum_valid && sum_ready;
  assign sum_data  = {1'b0, lhs_q} + {1'b0, rhs_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      lhs_full <= 1'b0;
      lhs_q    <= '0;
    end else if (lhs_take) begin
      lhs_full <= 1'b1;
      lhs_q    <= lhs_data;
    end else if (sum_take) begin
      lhs_full <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rhs_full <= 1'b0;
      rhs_q    <= '0;
    end else if (rhs_take) begin
      rhs_full <= 1'b1;
      rhs_q    <= rhs_data;
    end else if (sum_take) begin
      rhs_full <= 1'b0;
    end
  end
endmodule

// File: rtl/join_adder_props.sv
module join_adder_props #(
  parameter int OPW = 16
) (
  input logic           clk,
  input logic           rst,
  input logic           lhs_valid,
  input logic           lhs_ready,
  input logic           rhs_valid,
  input logic           rhs_ready,
  input logic           sum_valid,
  input logic           sum_ready,
  input logic [OPW:0]   sum_data
);
  p_join_needs_both_r3: assert property (@(posedge clk) disable iff (rst)
    sum_valid |-> (!lhs_ready && !rhs_ready));

  p_lhs_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (lhs_valid && lhs_ready) |=> !lhs_ready);

  p_rhs_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (rhs_valid && rhs_ready) |=> !rhs_ready);

  p_stall_stable_r6: assert property (@(posedge clk) disable iff (rst)
    (sum_valid && !sum_ready) |=> (sum_valid && $stable(sum_data)));

  p_release_r7: assert property (@(posedge clk) disable iff (rst)
    (sum_valid && sum_ready) |=> (lhs_ready && rhs_ready && !sum_valid));

  p_both_same_edge_r8: assert property (@(posedge clk) disable iff (rst)
    (lhs_valid && lhs_ready && rhs_valid && rhs_ready) |=> sum_valid);
endmodule

bind join_adder join_adder_props #(.OPW(OPW)) u_props (
  .clk(clk), .rst(rst),
  .lhs_valid(lhs_valid), .lhs_ready(lhs_ready),
  .rhs_valid(rhs_valid), .rhs_ready(rhs_ready),
  .sum_valid(sum_valid), .sum_ready(sum_ready), .sum_data(sum_data)
);

// File: tb/join_adder_test.sv
`timescale 1ns/1ps
module join_adder_test;
  localparam int OPW = 16;

  logic clk = 1'b0;
  logic rst;
  logic lhs_valid, rhs_valid, sum_ready;
  logic [OPW-1:0] lhs_data, rhs_data;
  logic lhs_ready, rhs_ready, sum_valid;
  logic [OPW:0] sum_data;

  int checks = 0;
  int errors = 0;
  logic [OPW:0] expq[$];
  bit stream_on = 0;
  int unsigned seed = 32'h1234_5678;

  always #2 clk = ~clk;

  join_adder #(.OPW(OPW)) uut (
    .clk(clk), .rst(rst),
    .lhs_valid(lhs_valid), .lhs_ready(lhs_ready), .lhs_data(lhs_data),
    .rhs_valid(rhs_valid), .rhs_ready(rhs_ready), .rhs_data(rhs_data),
    .sum_valid(sum_valid), .sum_ready(sum_ready), .sum_data(sum_data)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int unsigned rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed >> 8;
  endfunction

  task automatic send_lhs(input logic [OPW-1:0] v, input int gap);
    bit r;
    repeat (gap) @(negedge clk);
    lhs_valid = 1'b1; lhs_data = v;
    forever begin
      r = lhs_ready;
      @(negedge clk);
      if (r) break;
    end
    lhs_valid = 1'b0;
  endtask

  task automatic send_rhs(input logic [OPW-1:0] v, input int gap);
    bit r;
    repeat (gap) @(negedge clk);
    rhs_valid = 1'b1; rhs_data = v;
    forever begin
      r = rhs_ready;
      @(negedge clk);
      if (r) break;
    end
    rhs_valid = 1'b0;
  endtask

  task automatic push(input logic [OPW-1:0] a, input logic [OPW-1:0] b);
    expq.push_back({1'b0, a} + {1'b0, b});
  endtask

  // monitor: samples 1 ns after the falling edge, well before the next rising edge
  bit prev_fire = 0, prev_stall = 0;
  logic [OPW:0] prev_data = '0;
  initial begin
    forever begin
      @(negedge clk); #1;
      if (rst) begin
        prev_fire = 0; prev_stall = 0;
      end else begin
        if (prev_fire)
          chk(lhs_ready && rhs_ready && !sum_valid, "R7 release",
              {lhs_ready, rhs_ready, sum_valid}, 3'b110);
        if (prev_stall)
          chk(sum_valid && sum_data == prev_data, "R6 stall",
              sum_data, prev_data);
        if (sum_valid && sum_ready) begin
          if (expq.size() == 0) chk(1'b0, "R2 unexpected sum", sum_data, 0);
          else begin
            logic [OPW:0] e;
            e = expq.pop_front();
            chk(sum_data == e, "R2 sum", sum_data, e);
          end
        end
        prev_fire  = sum_valid && sum_ready;
        prev_stall = sum_valid && !sum_ready;
        prev_data  = sum_data;
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (stream_on) sum_ready = (rnd() % 3) != 0;
    end
  end

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected=<%0d", cyc, 20000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    rst = 1'b1; lhs_valid = 0; rhs_valid = 0; sum_ready = 0;
    lhs_data = '0; rhs_data = '0;
    repeat (3) @(negedge clk);
    chk(lhs_ready && rhs_ready && !sum_valid && sum_data == 0, "R1 reset",
        {lhs_ready, rhs_ready, sum_valid, sum_data}, {3'b110, 17'h0});
    rst = 1'b0;
    @(negedge clk);
    chk(lhs_ready && rhs_ready && !sum_valid && sum_data == 0, "R1 after reset",
        {lhs_ready, rhs_ready, sum_valid, sum_data}, {3'b110, 17'h0});

    // left first, right later
    push(16'd100, 16'd200);
    send_lhs(16'd100, 0);
    chk(!sum_valid, "R3 one operand", sum_valid, 0);
    chk(rhs_ready, "R4 other still ready", rhs_ready, 1);
    chk(!lhs_ready, "R5 held not ready", lhs_ready, 0);
    lhs_valid = 1'b1; lhs_data = 16'd999;
    repeat (3) @(negedge clk);
    lhs_valid = 1'b0;
    chk(!sum_valid && rhs_ready, "R3 still waiting", {sum_valid, rhs_ready}, 2'b01);
    send_rhs(16'd200, 2);
    chk(sum_valid, "R3 join met", sum_valid, 1);
    chk(sum_data == 17'd300, "R5 ignored write", sum_data, 300);
    repeat (3) @(negedge clk);
    sum_ready = 1'b1;
    @(negedge clk);
    sum_ready = 1'b0;
    @(negedge clk);

    // right first, left later
    push(16'h1234, 16'h0042);
    send_rhs(16'h0042, 0);
    chk(lhs_ready && !sum_valid, "R4 reverse order", {lhs_ready, sum_valid}, 2'b10);
    send_lhs(16'h1234, 1);
    sum_ready = 1'b1;
    @(negedge clk);
    sum_ready = 1'b0;
    @(negedge clk);

    // both in the same edge, carry out
    push(16'hFFFF, 16'hFFFF);
    fork
      send_lhs(16'hFFFF, 0);
      send_rhs(16'hFFFF, 0);
    join
    chk(sum_valid, "R8 same edge", sum_valid, 1);
    chk(sum_data == 17'h1FFFE, "R2 carry kept", sum_data, 17'h1FFFE);
    @(negedge clk);
    sum_ready = 1'b1;
    @(negedge clk);
    sum_ready = 1'b0;
    @(negedge clk);

    // streaming with random gaps and a toggling reader
    stream_on = 1;
    for (int i = 0; i < 40; i++) begin
      logic [OPW-1:0] a, b;
      int ga, gb;
      a = rnd(); b = rnd();
      ga = (i % 4 == 0) ? 0 : rnd() % 3;
      gb = (i % 4 == 0) ? 0 : rnd() % 3;
      push(a, b);
      fork
        send_lhs(a, ga);
        send_rhs(b, gb);
      join
    end
    repeat (60) @(negedge clk);
    stream_on = 0;
    sum_ready = 1'b0;
    @(negedge clk);
    chk(expq.size() == 0, "R2 all sums delivered", expq.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule